// File: doc/BRIEF.md
# Frame-Synchronous Scaler Control Registers

This block is the register slave that sits in front of a video scaler. A host reaches it through a 32-bit word-addressed bus with per-byte write enables, and it stores the run bit, the output frame width and height, and four coefficient bank selectors. Two selectors are write banks, one horizontal and one vertical. They steer host coefficient loads. The other two are read banks, which pick the coefficient sets used while filtering.

The scaling datapath signals the edges of each frame with `frameStart` and `frameEnd` strobes. On a start with the run bit set, the block copies the dimensions and the two read-bank selectors into a shadow set. That shadow set drives the datapath and does not change until the next accepted start. This lets the host rewrite any register mid-frame without disturbing the frame in flight.

A start that arrives with the run bit clear is refused, so the core halts cleanly on a frame boundary. The block reports whether a frame is in flight. It also raises a one-cycle flag when a coefficient load targets the bank the running frame is reading.

Top module: `sclr_cfg_top`

## Requirements
- R1: After reset every register reads 0, `frameBusy`, `bankClash` and `busRValid` are 0, and all shadow outputs are 0.
- R2: A read strobe sampled on a clock edge produces `busRValid` = 1 and the addressed register's value on `busRData` in the next cycle only.
- R3: A write updates only the byte lanes whose `busByteEn` bit is 1 (bit i covers data bits 8i+7..8i); the other lanes keep their previous contents.
- R4: Word address 0 holds the run bit in bit 0; address 3 holds the output width and 4 the output height in bits 15..0; addresses 5, 6, 7 and 8 hold the horizontal write bank, horizontal read bank, vertical write bank and vertical read bank in bits 1..0. All other bits read 0.
- R5: Writes to address 1 (status), address 2 (reserved) and addresses 9..15 have no effect. Addresses 2 and 9..15 read 0.
- R6: Address 1 reads `frameBusy` in bit 0 and 0 in all other bits.
- R7: A `frameStart` with the run bit at 1 loads width, height and both read banks into the shadow outputs and sets `frameBusy`, both visible in the next cycle.
- R8: A `frameStart` with the run bit at 0 leaves the shadow outputs unchanged and leaves `frameBusy` at 0 in the next cycle.
- R9: `frameEnd` clears `frameBusy` in the next cycle. When `frameStart` arrives in the same cycle, the start takes precedence.
- R10: Host writes made while a frame is busy change register readback but not the shadow outputs; the new values reach the shadow only at the next accepted start.
- R11: While `frameBusy` is 1, a horizontal (vertical) coefficient write strobe raises `bankClash` for one cycle, in the next cycle, exactly when the current horizontal (vertical) write bank equals the shadow horizontal (vertical) read bank. While idle, `bankClash` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Word address |
| busWrite | input | 1 | Write strobe |
| busRead | input | 1 | Read strobe |
| busByteEn | input | 4 | Byte lane enables for writes |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data, valid with `busRValid` |
| busRValid | output | 1 | Read data valid, one cycle after `busRead` |
| frameStart | input | 1 | Frame start strobe from the datapath |
| frameEnd | input | 1 | Frame end strobe from the datapath |
| hCoefWr | input | 1 | Horizontal coefficient write strobe |
| vCoefWr | input | 1 | Vertical coefficient write strobe |
| frameBusy | output | 1 | A frame is in flight |
| bankClash | output | 1 | Coefficient write hit the bank in use |
| shWidth | output | 16 | Shadow output width |
| shHeight | output | 16 | Shadow output height |
| shHRdBank | output | 2 | Shadow horizontal read bank |
| shVRdBank | output | 2 | Shadow vertical read bank |

## Verification
Each result here is due exactly one clock after the stimulus that causes it:
- Read data and its valid flag follow the read strobe by one clock.
- Shadow outputs and `frameBusy` change one clock after a frame strobe.
- `bankClash` follows a coefficient strobe by one clock.
- Register contents change at the edge that samples a write.

The bench drives every input just after a falling edge and holds it across one rising edge. It samples results at the following falling edge, so each check reads the cycle in which the result is due and nothing earlier or later.

// File: rtl/sclr_cfg_pkg.sv
package sclr_cfg_pkg;
  parameter int DATA_W = 32;
  parameter int ADDR_W = 4;
  parameter int DIM_W  = 16;
  parameter int BANK_W = 2;
  localparam int BE_W  = DATA_W / 8;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 4'd0,
    A_STAT   = 4'd1,
    A_RSVD   = 4'd2,
    A_WIDTH  = 4'd3,
    A_HEIGHT = 4'd4,
    A_HWR    = 4'd5,
    A_HRD    = 4'd6,
    A_VWR    = 4'd7,
    A_VRD    = 4'd8
  } addr_e;

  typedef struct packed {
    logic              go;
    logic [DIM_W-1:0]  width;
    logic [DIM_W-1:0]  height;
    logic [BANK_W-1:0] hWr;
    logic [BANK_W-1:0] hRd;
    logic [BANK_W-1:0] vWr;
    logic [BANK_W-1:0] vRd;
  } cfg_t;

  typedef struct packed {
    logic [DIM_W-1:0]  width;
    logic [DIM_W-1:0]  height;
    logic [BANK_W-1:0] hRd;
    logic [BANK_W-1:0] vRd;
  } shadow_t;

  typedef struct packed {
    logic loadShadow;
    logic setBusy;
    logic clrBusy;
  } strobe_t;

  function automatic logic [DATA_W-1:0] mergeBytes(input logic [DATA_W-1:0] oldW,
                                                   input logic [DATA_W-1:0] newW,
                                                   input logic [BE_W-1:0]   be);
    logic [DATA_W-1:0] res;
    for (int i = 0; i < BE_W; i++) begin
      res[8*i +: 8] = be[i] ? newW[8*i +: 8] : oldW[8*i +: 8];
    end
    return res;
  endfunction
endpackage

// File: rtl/sclr_cfg_regfile.sv
module sclr_cfg_regfile
  import sclr_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [BE_W-1:0]   busByteEn,
  input  logic [DATA_W-1:0] busWData,
  input  strobe_t           strobe,
  input  logic              busy,
  output logic [DATA_W-1:0] busRData,
  output logic              busRValid,
  output cfg_t              liveCfg,
  output shadow_t           shadow
);
  logic [DATA_W-1:0] curWord;
  logic [DATA_W-1:0] merged;

  // readback mux, also the base for byte-lane merging
  always_comb begin
    curWord = '0;
    case (addr_e'(busAddr))
      A_CTRL:   curWord[0]          = liveCfg.go;
      A_STAT:   curWord[0]          = busy;
      A_WIDTH:  curWord[DIM_W-1:0]  = liveCfg.width;
      A_HEIGHT: curWord[DIM_W-1:0]  = liveCfg.height;
      A_HWR:    curWord[BANK_W-1:0] = liveCfg.hWr;
      A_HRD:    curWord[BANK_W-1:0] = liveCfg.hRd;
      A_VWR:    curWord[BANK_W-1:0] = liveCfg.vWr;
      A_VRD:    curWord[BANK_W-1:0] = liveCfg.vRd;
      default:  curWord             = '0;
    endcase
  end

  assign merged = mergeBytes(curWord, busWData, busByteEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveCfg <= '0;
    end else if (busWrite) begin
      case (addr_e'(busAddr))
        A_CTRL:   liveCfg.go     <= merged[0];
        A_WIDTH:  liveCfg.width  <= merged[DIM_W-1:0];
        A_HEIGHT: liveCfg.height <= merged[DIM_W-1:0];
        A_HWR:    liveCfg.hWr    <= merged[BANK_W-1:0];
        A_HRD:    liveCfg.hRd    <= merged[BANK_W-1:0];
        A_VWR:    liveCfg.vWr    <= merged[BANK_W-1:0];
        A_VRD:    liveCfg.vRd    <= merged[BANK_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRValid <= 1'b0;
      busRData  <= '0;
    end else begin
      busRValid <= busRead;
      busRData  <= busRead ? curWord : '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadow <= '0;
    end else if (strobe.loadShadow) begin
      shadow.width  <= liveCfg.width;
      shadow.height <= liveCfg.height;
      shadow.hRd    <= liveCfg.hRd;
      shadow.vRd    <= liveCfg.vRd;
    end
  end
endmodule

// File: rtl/sclr_cfg_frame_ctrl.sv
module sclr_cfg_frame_ctrl
  import sclr_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              frameEnd,
  input  logic              go,
  input  logic              hCoefWr,
  input  logic              vCoefWr,
  input  logic [BANK_W-1:0] hWrBank,
  input  logic [BANK_W-1:0] vWrBank,
  input  logic [BANK_W-1:0] shHRd,
  input  logic [BANK_W-1:0] shVRd,
  output strobe_t           strobe,
  output logic              busy,
  output logic              bankClash
);
  logic hHit;
  logic vHit;

  always_comb begin
    strobe.loadShadow = frameStart & go;
    strobe.setBusy    = frameStart & go;
    strobe.clrBusy    = frameEnd | (frameStart & ~go);
  end

  assign hHit = hCoefWr && (hWrBank == shHRd);
  assign vHit = vCoefWr && (vWrBank == shVRd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      bankClash <= 1'b0;
    end else begin
      if (strobe.setBusy)      busy <= 1'b1;
      else if (strobe.clrBusy) busy <= 1'b0;
      bankClash <= busy & (hHit | vHit);
    end
  end
endmodule

// File: rtl/sclr_cfg_top.sv
module sclr_cfg_top
  import sclr_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [BE_W-1:0]   busByteEn,
  input  logic [DATA_W-1:0] busWData,
  output logic [DATA_W-1:0] busRData,
  output logic              busRValid,
  input  logic              frameStart,
  input  logic              frameEnd,
  input  logic              hCoefWr,
  input  logic              vCoefWr,
  output logic              frameBusy,
  output logic              bankClash,
  output logic [DIM_W-1:0]  shWidth,
  output logic [DIM_W-1:0]  shHeight,
  output logic [BANK_W-1:0] shHRdBank,
  output logic [BANK_W-1:0] shVRdBank
);
  cfg_t    liveCfg;
  shadow_t shadow;
  strobe_t strobe;
  logic    goBit;

  assign goBit = liveCfg.go;

  sclr_cfg_regfile u_regs (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWrite(busWrite), .busRead(busRead),
    .busByteEn(busByteEn), .busWData(busWData),
    .strobe(strobe), .busy(frameBusy),
    .busRData(busRData), .busRValid(busRValid),
    .liveCfg(liveCfg), .shadow(shadow)
  );

  sclr_cfg_frame_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .frameStart(frameStart), .frameEnd(frameEnd), .go(goBit),
    .hCoefWr(hCoefWr), .vCoefWr(vCoefWr),
    .hWrBank(liveCfg.hWr), .vWrBank(liveCfg.vWr),
    .shHRd(shadow.hRd), .shVRd(shadow.vRd),
    .strobe(strobe), .busy(frameBusy), .bankClash(bankClash)
  );

  assign shWidth   = shadow.width;
  assign shHeight  = shadow.height;
  assign shHRdBank = shadow.hRd;
  assign shVRdBank = shadow.vRd;
endmodule

// File: rtl/sclr_cfg_checker.sv
module sclr_cfg_checker
  import sclr_cfg_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busRead,
  input logic              busRValid,
  input logic              frameStart,
  input logic              frameEnd,
  input logic              goBit,
  input logic              frameBusy,
  input logic              bankClash,
  input logic [DIM_W-1:0]  shWidth,
  input logic [DIM_W-1:0]  shHeight
);
  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    busRead |=> busRValid) else $error("rvalid missing");                       // R2
  AST_RVALID_ONLY_READ: assert property (@(posedge clk) disable iff (!rstN)
    !busRead |=> !busRValid) else $error("spurious rvalid");                    // R2
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && goBit) |=> frameBusy) else $error("busy not set");           // R7
  AST_STOPPED_START: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && !goBit) |=> (!frameBusy && $stable(shWidth) && $stable(shHeight)))
    else $error("stopped start accepted");                                       // R8
  AST_END_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && !frameStart) |=> !frameBusy) else $error("busy not cleared");  // R9
  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> ($stable(shWidth) && $stable(shHeight)))
    else $error("shadow moved mid-frame");                                       // R10
  AST_CLASH_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    bankClash |-> $past(frameBusy)) else $error("clash while idle");            // R11
endmodule

bind sclr_cfg_top sclr_cfg_checker u_chk (
  .clk(clk), .rstN(rstN), .busRead(busRead), .busRValid(busRValid),
  .frameStart(frameStart), .frameEnd(frameEnd), .goBit(goBit),
  .frameBusy(frameBusy), .bankClash(bankClash),
  .shWidth(shWidth), .shHeight(shHeight)
);

// File: tb/test_sclr_cfg_top.sv
module test_sclr_cfg_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrite = 1'b0, busRead = 1'b0;
  logic [3:0]  busByteEn = '0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic        busRValid;
  logic        frameStart = 1'b0, frameEnd = 1'b0, hCoefWr = 1'b0, vCoefWr = 1'b0;
  logic        frameBusy, bankClash;
  logic [15:0] shWidth, shHeight;
  logic [1:0]  shHRdBank, shVRdBank;

  int nRun = 0, nFail = 0;
  logic [31:0] mdl [16];
  bit done = 0;

  always #4 clk = ~clk;

  sclr_cfg_top i_sclr_cfg_top (.*);

  function automatic logic [31:0] maskOf(input int a);
    case (a)
      0: return 32'h1;
      3, 4: return 32'hFFFF;
      5, 6, 7, 8: return 32'h3;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] applyBe(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = be[i] ? n[8*i +: 8] : o[8*i +: 8];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    busAddr = a[3:0]; busWData = d; busByteEn = be; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
    mdl[a] = applyBe(mdl[a], d, be) & maskOf(a);
  endtask

  task automatic rd(input int a, output logic [31:0] d, output logic v);
    @(negedge clk);
    busAddr = a[3:0]; busRead = 1'b1;
    @(negedge clk);
    busRead = 1'b0;
    d = busRData; v = busRValid;
  endtask

  task automatic pulse(input bit s, input bit e, input bit h, input bit vv);
    @(negedge clk);
    frameStart = s; frameEnd = e; hCoefWr = h; vCoefWr = vv;
    @(negedge clk);
    frameStart = 0; frameEnd = 0; hCoefWr = 0; vCoefWr = 0;
  endtask

  initial begin
    logic [31:0] d;
    logic v;
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", {31'b0, frameBusy}, 0);
    check("R1 clash", {31'b0, bankClash}, 0);
    check("R1 valid", {31'b0, busRValid}, 0);
    check("R1 shadow", {shWidth, shHeight}, 0);
    for (int a = 0; a < 16; a++) begin
      rd(a, d, v);
      check("R1 regs", d, 0);
      check("R2 valid", {31'b0, v}, 1);
    end
    // idle cycle: no valid after read ends (R2)
    @(negedge clk);
    check("R2 valid drops", {31'b0, busRValid}, 0);

    // constrained random writes / reads against model: R3 R4 R5
    for (int k = 0; k < 200; k++) begin
      int a, b;
      a = int'($urandom % 16);
      if (a == 0) a = 3;  // keep run bit low here
      wr(a, $urandom, 4'($urandom % 16));
      b = int'($urandom % 16);
      rd(b, d, v);
      check((b == 1 || b == 2 || b > 8) ? "R5 map" : "R3 R4 readback", d, (b == 1) ? 32'h0 : mdl[b]);
    end

    // directed byte lanes R3
    wr(3, 32'h0, 4'hF);
    wr(3, 32'hFFFF_FFFF, 4'b0001);
    rd(3, d, v); check("R3 low lane", d, 32'h00FF);
    wr(3, 32'hA5A5_A5A5, 4'b0010);
    rd(3, d, v); check("R3 second lane", d, 32'hA5FF);
    // R5 status/reserved writes ignored
    wr(1, 32'hFFFF_FFFF, 4'hF); rd(1, d, v); check("R5 status", d, 0);
    wr(2, 32'hFFFF_FFFF, 4'hF); rd(2, d, v); check("R5 reserved", d, 0);
    wr(12, 32'hFFFF_FFFF, 4'hF); rd(12, d, v); check("R5 unmapped", d, 0);

    // R8 start while stopped
    wr(3, 100, 4'hF);
    pulse(1, 0, 0, 0);
    check("R8 busy", {31'b0, frameBusy}, 0);
    check("R8 shadow", {16'b0, shWidth}, 0);

    // R7 accepted start
    wr(3, 640, 4'hF); wr(4, 480, 4'hF); wr(6, 2, 4'hF); wr(8, 1, 4'hF);
    wr(5, 0, 4'hF); wr(7, 0, 4'hF);
    wr(0, 1, 4'h1);
    rd(0, d, v); check("R4 go", d, 1);
    pulse(1, 0, 0, 0);
    check("R7 busy", {31'b0, frameBusy}, 1);
    check("R7 width", {16'b0, shWidth}, 640);
    check("R7 height", {16'b0, shHeight}, 480);
    check("R7 banks", {28'b0, shHRdBank, shVRdBank}, {28'b0, 2'd2, 2'd1});
    rd(1, d, v); check("R6 status busy", d, 1);

    // R10 writes mid-frame
    wr(3, 320, 4'hF);
    wr(6, 3, 4'hF);
    check("R10 shadow width", {16'b0, shWidth}, 640);
    check("R10 shadow bank", {30'b0, shHRdBank}, 2);
    rd(3, d, v); check("R10 readback", d, 320);

    // R11 clash
    wr(5, 2, 4'hF);
    pulse(0, 0, 1, 0);
    check("R11 h clash", {31'b0, bankClash}, 1);
    @(negedge clk); check("R11 one cycle", {31'b0, bankClash}, 0);
    wr(5, 3, 4'hF);
    pulse(0, 0, 1, 0);
    check("R11 h no clash", {31'b0, bankClash}, 0);
    wr(7, 1, 4'hF);
    pulse(0, 0, 0, 1);
    check("R11 v clash", {31'b0, bankClash}, 1);

    // R9 end of frame
    pulse(0, 1, 0, 0);
    check("R9 busy cleared", {31'b0, frameBusy}, 0);
    rd(1, d, v); check("R6 status idle", d, 0);
    pulse(0, 0, 0, 1);
    check("R11 idle no clash", {31'b0, bankClash}, 0);

    // R10 new values at next start
    pulse(1, 0, 0, 0);
    check("R10 next frame width", {16'b0, shWidth}, 320);
    check("R10 next frame bank", {30'b0, shHRdBank}, 3);
    // R9 start wins over end in same cycle
    pulse(1, 1, 0, 0);
    check("R9 start precedence", {31'b0, frameBusy}, 1);
    // R8 stop at boundary
    wr(0, 0, 4'h1);
    wr(3, 50, 4'hF);
    pulse(1, 0, 0, 0);
    check("R8 stopped busy", {31'b0, frameBusy}, 0);
    check("R8 stopped shadow", {16'b0, shWidth}, 320);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule